// File: doc/BRIEF.md
# Dual-Reload PWM Down-Counter Timer

This block is one timer channel built around a down-counter. Software sets a low-phase count, a high-phase count and a four-bit control word through a simple write port. When enabled in user-defined mode with the PWM bit set, the counter runs the low phase first and then alternates between the two phases. Each phase lasts its count plus one clock, and the output toggles each time the counter expires. Because every phase is at least one clock long, the output can never sit at 0 % or 100 % duty.

In free-running mode the counter reloads all ones after each expiry and the PWM output stays low. Every expiry raises a raw interrupt flag, and an end-of-interrupt strobe clears it. The interrupt line follows this flag unless the mask bit is set. The live counter value is always visible on a readback port.

The intended use is to disable the timer, write the counts and the control word, and then enable it. The low count is loaded when the enable turns on, so each enable starts a fresh low phase.

Top module: `pwm_dual_timer`

## Requirements
- R1: After synchronous reset, `pwm_out`, `irq_raw`, `irq` and `cur_val` are all 0.
- R2: A write with `wr_addr`=0 sets the low-phase count L, and `wr_addr`=1 sets the high-phase count H. Control is written with `wr_addr`=2: bit 0 enable, bit 1 mode (1 user-defined, 0 free-running), bit 2 interrupt mask, bit 3 PWM. In user-defined PWM mode the output alternates low for L+1 clocks and high for H+1 clocks. This includes L=H=0, where it toggles every clock.
- R3: In free-running mode the counter loads all ones on expiry and `pwm_out` stays low.
- R4: Every expiry sets `irq_raw`. `irq` equals `irq_raw` when the mask bit is 0 and stays 0 when the mask bit is 1.
- R5: A one-cycle `eoi` pulse with no expiry in the same cycle clears `irq_raw`. If an expiry and `eoi` fall in the same cycle, the expiry wins.
- R6: While enable is 0, `cur_val` holds its value and `pwm_out` is low.
- R7: A control write that turns enable on loads L one clock after the write edge and starts in the low phase. `pwm_out` therefore first rises L+2 sampled cycles after that write.
- R8: In user-defined mode with the PWM bit 0, `pwm_out` stays low while expiries still set `irq_raw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 low count, 1 high count, 2 control |
| wr_data | input | CNT_W | Write data |
| eoi | input | 1 | End-of-interrupt strobe, clears the raw flag |
| pwm_out | output | 1 | PWM output |
| cur_val | output | CNT_W | Current counter value |
| irq_raw | output | 1 | Interrupt status, ignoring the mask |
| irq | output | 1 | Masked interrupt line |

## Verification
The hardest case to reach is an `eoi` pulse that lands between two expiries. When phases are short, the flag is set again within a few clocks, so a clear is easy to miss. The stimulus waits for a PWM edge, which marks the cycle just after an expiry. It then issues the strobe inside the following six-clock high phase and samples the flag before the next expiry. A second hard case is the restart after a disable. To check it, the counts are rewritten to zero while the timer is stopped, and the low-first timing is measured from the enabling write.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef struct packed {
        logic pwm;    // bit 3
        logic mask;   // bit 2
        logic user;   // bit 1: 1 user-defined, 0 free-running
        logic en;     // bit 0
    } pdt_ctrl_t;

    typedef enum logic [1:0] {
        PDT_ADDR_LOW  = 2'd0,
        PDT_ADDR_HIGH = 2'd1,
        PDT_ADDR_CTRL = 2'd2
    } pdt_addr_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } pdt_phase_e;

    function automatic pdt_phase_e flip_phase(input pdt_phase_e p);
        return (p == PH_LOW) ? PH_HIGH : PH_LOW;
    endfunction

endpackage

// File: rtl/pdt_regs.sv
module pdt_regs
    import pdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] ld_low,
    output logic [CNT_W-1:0] ld_high,
    output pdt_ctrl_t        ctrl
);
    localparam int CTRL_W = $bits(pdt_ctrl_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_low  <= '0;
            ld_high <= '0;
            ctrl    <= '0;
        end else if (wr_en) begin
            case (pdt_addr_e'(wr_addr))
                PDT_ADDR_LOW:  ld_low  <= wr_data;
                PDT_ADDR_HIGH: ld_high <= wr_data;
                PDT_ADDR_CTRL: ctrl    <= pdt_ctrl_t'(wr_data[CTRL_W-1:0]);
                default:       ;
            endcase
        end
    end

    AST_LOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0) |=> ld_low == $past(wr_data)); // R2

endmodule

// File: rtl/pdt_counter.sv
module pdt_counter
    import pdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             user_mode,
    input  logic [CNT_W-1:0] ld_low,
    input  logic [CNT_W-1:0] ld_high,
    output logic [CNT_W-1:0] cnt,
    output pdt_phase_e       phase,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic started;

    assign expire = run && started && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            phase   <= PH_LOW;
            started <= 1'b0;
        end else if (!run) begin
            phase   <= PH_LOW;
            started <= 1'b0;
        end else if (!started) begin
            cnt     <= ld_low;
            phase   <= PH_LOW;
            started <= 1'b1;
        end else if (cnt == '0) begin
            phase <= flip_phase(phase);
            if (!user_mode)
                cnt <= CNT_MAX;
            else
                cnt <= (phase == PH_LOW) ? ld_high : ld_low;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cnt)); // R6

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (run && !started) |=> (cnt == $past(ld_low)) && (phase == PH_LOW)); // R7

    AST_EXPIRY_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        expire |=> phase != $past(phase)); // R2

    AST_FREE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (expire && !user_mode) |=> cnt == CNT_MAX); // R3

endmodule

// File: rtl/pdt_irq.sv
module pdt_irq (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic eoi,
    input  logic mask,
    output logic raw,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            raw <= 1'b0;
        else if (expire)
            raw <= 1'b1;
        else if (eoi)
            raw <= 1'b0;
    end

    assign irq = raw && !mask;

    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (rst)
        expire |=> raw); // R4

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (eoi && !expire) |=> !raw); // R5

endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
    import pdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             eoi,
    output logic             pwm_out,
    output logic [CNT_W-1:0] cur_val,
    output logic             irq_raw,
    output logic             irq
);
    logic [CNT_W-1:0] ld_low;
    logic [CNT_W-1:0] ld_high;
    pdt_ctrl_t        ctrl;
    pdt_phase_e       phase;
    logic             expire;

    pdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ld_low  (ld_low),
        .ld_high (ld_high),
        .ctrl    (ctrl)
    );

    pdt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.en),
        .user_mode (ctrl.user),
        .ld_low    (ld_low),
        .ld_high   (ld_high),
        .cnt       (cur_val),
        .phase     (phase),
        .expire    (expire)
    );

    pdt_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .eoi    (eoi),
        .mask   (ctrl.mask),
        .raw    (irq_raw),
        .irq    (irq)
    );

    assign pwm_out = ctrl.en && ctrl.user && ctrl.pwm && (phase == PH_HIGH);

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (irq_raw && ctrl.mask) |-> !irq); // R4

endmodule

// File: tb/pwm_dual_timer_tb.sv
module pwm_dual_timer_tb;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic eoi = 1'b0;
    logic pwm_out, irq_raw, irq;
    logic [W-1:0] cur_val;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_dual_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .eoi(eoi), .pwm_out(pwm_out), .cur_val(cur_val), .irq_raw(irq_raw), .irq(irq)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // scoreboard: expected runs encoded as level<<16 | length
    int exp_q[$];
    bit mon_on = 0;
    bit mon_started = 0;
    logic mon_lvl;
    int run_len;

    task automatic push_run(input bit lvl, input int len);
        exp_q.push_back((int'(lvl) << 16) | len);
    endtask

    always @(negedge clk) begin
        if (!mon_on) begin
            mon_started = 0;
        end else if (!mon_started) begin
            if (pwm_out) begin mon_started = 1; mon_lvl = 1'b1; run_len = 1; end
        end else if (pwm_out == mon_lvl) begin
            run_len++;
        end else begin
            if (exp_q.size() > 0) begin
                int e;
                e = exp_q.pop_front();
                chk("R2 run", (int'(mon_lvl) << 16) | run_len, e);
            end
            mon_lvl = pwm_out; run_len = 1;
        end
    end

    task automatic drain(input string req);
        int t = 0;
        mon_on = 1;
        while (exp_q.size() > 0 && t < 500) begin @(negedge clk); t++; end
        chk(req, exp_q.size(), 0);
        mon_on = 0;
        exp_q.delete();
        @(negedge clk);
    endtask

    // count low samples after an enabling write (task returns at negedge after write edge)
    task automatic low_first(input string req, input int exp_n);
        int n = 0;
        while (!pwm_out && n < 100) begin n++; @(negedge clk); end
        chk(req, n, exp_n);
    endtask

    task automatic pulse_eoi();
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        bit bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pwm", pwm_out, 0);
        chk("R1 raw", irq_raw, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cnt", cur_val, 0);

        // user PWM, L=3 H=5
        wr(2'd0, 3); wr(2'd1, 5);
        wr(2'd2, 32'hB);
        low_first("R7 first rise L=3", 5);
        push_run(1, 6); push_run(0, 4); push_run(1, 6); push_run(0, 4);
        drain("R2 L3 H5");
        chk("R4 raw set", irq_raw, 1);
        chk("R4 irq unmasked", irq, 1);

        // eoi between expiries
        @(posedge pwm_out); pulse_eoi();
        chk("R5 eoi clears", irq_raw, 0);

        // mask
        wr(2'd2, 32'hF);
        @(posedge pwm_out); @(negedge clk);
        chk("R4 masked raw", irq_raw, 1);
        chk("R4 masked irq", irq, 0);

        // disable holds
        wr(2'd2, 32'hE);
        held = cur_val; bad = 0;
        repeat (6) begin @(negedge clk); if (pwm_out) bad = 1; end
        chk("R6 hold", cur_val, held);
        chk("R6 pwm low", bad, 0);

        // restart with zero counts
        wr(2'd0, 0); wr(2'd1, 0);
        wr(2'd2, 32'hB);
        low_first("R7 first rise L=0", 2);
        push_run(1, 1); push_run(0, 1); push_run(1, 1); push_run(0, 1);
        drain("R2 L0 H0");

        // PWM bit off in user mode
        wr(2'd2, 32'h0);
        wr(2'd0, 2); wr(2'd1, 2);
        pulse_eoi();
        chk("R5 eoi idle", irq_raw, 0);
        wr(2'd2, 32'h3);
        bad = 0;
        repeat (20) begin @(negedge clk); if (pwm_out) bad = 1; end
        chk("R8 pwm low", bad, 0);
        chk("R8 raw set", irq_raw, 1);

        // free-running, L=2
        wr(2'd2, 32'h0);
        pulse_eoi();
        wr(2'd2, 32'h9);
        bad = 0;
        repeat (4) begin @(negedge clk); if (pwm_out) bad = 1; end
        chk("R3 reload ones", cur_val, {W{1'b1}});
        chk("R3 raw", irq_raw, 1);
        repeat (10) begin @(negedge clk); if (pwm_out) bad = 1; end
        chk("R3 pwm low", bad, 0);
        chk("R3 counting", cur_val, {W{1'b1}} - 10);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule